// File: doc/BRIEF.md
# Pin Port with Sticky Interrupt Detector

This block is one 32-pin general-purpose I/O port. Software drives pins through an output-value register and an output-enable register and reads the pin state back through an input register. Each pin can also raise an interrupt. A rising edge, a falling edge, a high level or a low level may each be chosen as the trigger. A detected event sets a sticky status bit, and one combined interrupt line reports any status bit whose enable bit is set.

All registers sit on a simple bus with address, write data, write strobe and read data. Bits 7:4 of the address select a register and bits 3:0 select how a write is applied. Offset 0x0 replaces the register. Offset 0x4 ORs the written mask into it. Offset 0x8 clears the bits that are set in the mask. This lets software change single bits without a read-modify-write. Pin inputs pass through a two-flop synchroniser before they reach the input register and the detectors.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset every register reads 0, `pin_oe` and `pin_out` are 0, and `irq` is low.
- R2: Registers are at 0x00 output value, 0x10 input, 0x20 output enable, 0x30 interrupt source select, 0x40 interrupt enable, 0x50 level select, 0x60 polarity and 0x70 status. A write at offset 0x0 replaces the register. A read at offset 0x0, 0x4 or 0x8 returns the register's value.
- R3: A write at register base + 0x4 sets every register bit whose write-data bit is 1 and leaves the other bits unchanged.
- R4: A write at register base + 0x8 clears every register bit whose write-data bit is 1 and leaves the other bits unchanged.
- R5: `pin_out` equals the output value register and `pin_oe` equals the output enable register. Bit n of each register controls pin n.
- R6: The input register shows `pin_in` two clock edges after the pin changes. Writes to the input register have no effect.
- R7: When a pin's level-select bit is 0, the pin is edge-sensitive. Polarity bit 1 selects the rising edge and polarity bit 0 selects the falling edge. A detected edge sets the pin's status bit one edge after the edge becomes visible in the input register.
- R8: When a pin's level-select bit is 1, the pin is level-sensitive. Polarity bit 1 selects high and polarity bit 0 selects low. The status bit is set again on every cycle that the level persists.
- R9: The hardware sets a status bit only when that pin's source-select bit is 1.
- R10: Writing 1s to the status clear alias (0x78) clears pending bits. If a hardware set and a clear hit the same bit in one cycle, the bit stays set.
- R11: `irq` is high exactly when some bit is 1 in both the status register and the enable register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pin_in | input | 32 | Raw pin levels |
| pin_out | output | 32 | Output values |
| pin_oe | output | 32 | Output enables |
| irq | output | 1 | Combined interrupt |

## Verification
Every writable register is tested with three different masks at each of its three write offsets. These sweeps separate replace, OR and clear behaviour, and they catch decode slips between neighbouring registers. Each of the four trigger types is tested with two pin-transition pairs that mix rising, falling and unchanged pins. The source mask leaves some pins disabled, so the pattern of expected status bits shows which condition was matched and whether the source gating works. A held high level during a clear write tests the rule that a hardware set beats a software clear. The interrupt line is checked with the enable register cleared, half set, and fully set.

// File: rtl/gpio_irq_port.sv
module gpio_irq_port #(
  parameter int NPIN = 32,
  parameter int AW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   bus_addr,
  input  logic [NPIN-1:0] bus_wdata,
  input  logic            bus_we,
  output logic [NPIN-1:0] bus_rdata,
  input  logic [NPIN-1:0] pin_in,
  output logic [NPIN-1:0] pin_out,
  output logic [NPIN-1:0] pin_oe,
  output logic            irq
);
  localparam logic [3:0] IX_OUT  = 4'd0;
  localparam logic [3:0] IX_IN   = 4'd1;
  localparam logic [3:0] IX_OE   = 4'd2;
  localparam logic [3:0] IX_SRC  = 4'd3;
  localparam logic [3:0] IX_EN   = 4'd4;
  localparam logic [3:0] IX_LEV  = 4'd5;
  localparam logic [3:0] IX_POL  = 4'd6;
  localparam logic [3:0] IX_STAT = 4'd7;
  localparam logic [3:0] OP_PUT  = 4'h0;
  localparam logic [3:0] OP_SET  = 4'h4;
  localparam logic [3:0] OP_CLR  = 4'h8;

  logic [NPIN-1:0] out_q, oe_q, src_q, en_q, lev_q, pol_q, stat_q;
  logic [NPIN-1:0] sy1_q, sy2_q, sy3_q;
  logic [NPIN-1:0] rise, fall, cond, hw_set;

  wire [3:0] ix = bus_addr[7:4];
  wire [3:0] op = bus_addr[3:0];

  function automatic logic [NPIN-1:0] upd(input logic [NPIN-1:0] cur,
                                          input logic hit,
                                          input logic [3:0] mode,
                                          input logic [NPIN-1:0] wd);
    logic [NPIN-1:0] r;
    r = cur;
    if (hit) begin
      case (mode)
        OP_PUT:  r = wd;
        OP_SET:  r = cur | wd;
        OP_CLR:  r = cur & ~wd;
        default: r = cur;
      endcase
    end
    return r;
  endfunction

  assign rise   = sy2_q & ~sy3_q;
  assign fall   = ~sy2_q & sy3_q;
  assign cond   = (lev_q & ((pol_q & sy2_q) | (~pol_q & ~sy2_q)))
                | (~lev_q & ((pol_q & rise) | (~pol_q & fall)));
  assign hw_set = src_q & cond;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1_q <= '0;
      sy2_q <= '0;
      sy3_q <= '0;
    end else begin
      sy1_q <= pin_in;
      sy2_q <= sy1_q;
      sy3_q <= sy2_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      oe_q   <= '0;
      src_q  <= '0;
      en_q   <= '0;
      lev_q  <= '0;
      pol_q  <= '0;
      stat_q <= '0;
    end else begin
      out_q  <= upd(out_q,  bus_we && ix == IX_OUT,  op, bus_wdata);
      oe_q   <= upd(oe_q,   bus_we && ix == IX_OE,   op, bus_wdata);
      src_q  <= upd(src_q,  bus_we && ix == IX_SRC,  op, bus_wdata);
      en_q   <= upd(en_q,   bus_we && ix == IX_EN,   op, bus_wdata);
      lev_q  <= upd(lev_q,  bus_we && ix == IX_LEV,  op, bus_wdata);
      pol_q  <= upd(pol_q,  bus_we && ix == IX_POL,  op, bus_wdata);
      stat_q <= upd(stat_q, bus_we && ix == IX_STAT, op, bus_wdata) | hw_set;
    end
  end

  always_comb begin
    case (ix)
      IX_OUT:  bus_rdata = out_q;
      IX_IN:   bus_rdata = sy2_q;
      IX_OE:   bus_rdata = oe_q;
      IX_SRC:  bus_rdata = src_q;
      IX_EN:   bus_rdata = en_q;
      IX_LEV:  bus_rdata = lev_q;
      IX_POL:  bus_rdata = pol_q;
      IX_STAT: bus_rdata = stat_q;
      default: bus_rdata = '0;
    endcase
  end

  assign pin_out = out_q;
  assign pin_oe  = oe_q;
  assign irq     = |(stat_q & en_q);
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk #(
  parameter int NPIN = 32,
  parameter int AW   = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_we,
  input logic [AW-1:0]   bus_addr,
  input logic [NPIN-1:0] bus_wdata,
  input logic [NPIN-1:0] pin_out,
  input logic [NPIN-1:0] pin_oe,
  input logic            irq,
  input logic [NPIN-1:0] src,
  input logic [NPIN-1:0] lev,
  input logic [NPIN-1:0] pol,
  input logic [NPIN-1:0] en,
  input logic [NPIN-1:0] stat,
  input logic [NPIN-1:0] din
);
  AST_SRC_GATES_SET: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> ((stat & ~$past(stat) & ~$past(src)) == '0)); // R9
  AST_HIGH_LEVEL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(src & lev & pol & din) & ~stat) == '0)); // R10
  AST_PINS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> ($stable(pin_out) && $stable(pin_oe))); // R5
  AST_OE_SET_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr[7:0] == 8'h24) |=> ((pin_oe & $past(bus_wdata)) == $past(bus_wdata))); // R3
  AST_EN_CLR_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr[7:0] == 8'h48) |=> ((en & $past(bus_wdata)) == '0)); // R4
  AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (stat != '0)); // R11
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.NPIN(NPIN), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq),
  .src(src_q), .lev(lev_q), .pol(pol_q), .en(en_q), .stat(stat_q), .din(sy2_q)
);

// File: tb/gpio_irq_port_tb.sv
module gpio_irq_port_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe;
  logic        irq;
  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  gpio_irq_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] pats [3];
    logic [31:0] srcm, a, b, exp, e_lo, e_hi;
    logic [7:0]  base;
    pats[0] = 32'hA5A5_0F0F; pats[1] = 32'h1234_8001; pats[2] = 32'hFF00_F0F0;
    srcm = 32'hFFFF_00FF;

    cyc(2);
    rst_n = 1'b1;
    cyc(1);
    for (int r = 0; r < 8; r++) rd(8'(r * 16), 32'h0, "R1 reset reg");
    chk("R1 pin_oe", pin_oe, 32'h0);
    chk("R1 pin_out", pin_out, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);

    for (int r = 0; r < 7; r++) begin
      if (r == 1) continue;
      base = 8'(r * 16);
      for (int p = 0; p < 3; p++) begin
        wr(base, pats[p]);
        rd(base, pats[p], "R2 put");
        rd(base + 8'h4, pats[p], "R2 read set alias");
        rd(base + 8'h8, pats[p], "R2 read clr alias");
        wr(base + 8'h4, pats[(p + 1) % 3]);
        exp = pats[p] | pats[(p + 1) % 3];
        rd(base, exp, "R3 set alias");
        wr(base + 8'h8, pats[(p + 2) % 3]);
        exp = exp & ~pats[(p + 2) % 3];
        rd(base, exp, "R4 clr alias");
        if (r == 0) chk("R5 pin_out", pin_out, exp);
        if (r == 2) chk("R5 pin_oe", pin_oe, exp);
      end
      wr(base, 32'h0);
    end
    rd(8'h70, 32'h0, "R9 no status with sources off");

    pin_in = 32'hC3C3_5A5A;
    cyc(1);
    rd(8'h10, 32'h0, "R6 one edge not yet visible");
    cyc(1);
    rd(8'h10, 32'hC3C3_5A5A, "R6 visible after two edges");
    wr(8'h10, 32'h1111_1111);
    rd(8'h10, 32'hC3C3_5A5A, "R6 write to input ignored");

    for (int t = 0; t < 4; t++) begin
      for (int k = 0; k < 2; k++) begin
        a = (k == 0) ? 32'h0F0F_3C3C : 32'hF0F0_AA55;
        b = (k == 0) ? 32'h00FF_5A5A : 32'h0F0F_55AA;
        pin_in = a;
        cyc(4);
        wr(8'h50, t[0] ? 32'hFFFF_FFFF : 32'h0);
        wr(8'h60, t[1] ? 32'hFFFF_FFFF : 32'h0);
        wr(8'h30, srcm);
        wr(8'h78, 32'hFFFF_FFFF);
        e_lo = t[0] ? ((t[1] ? a : ~a) & srcm) : 32'h0;
        rd(8'h70, e_lo, t[0] ? "R8 level after clear" : "R7 no edge while stable");
        pin_in = b;
        cyc(3);
        if (t[0]) e_hi = ((t[1] ? a : ~a) | (t[1] ? b : ~b)) & srcm;
        else      e_hi = (t[1] ? (b & ~a) : (a & ~b)) & srcm;
        rd(8'h70, e_hi, t[0] ? "R8 level sticky" : "R7 edge detect");
        chk("R11 irq off with enable 0", {31'h0, irq}, 32'h0);
        wr(8'h40, 32'h0000_FFFF);
        chk("R11 irq low half", {31'h0, irq}, {31'h0, |(e_hi & 32'h0000_FFFF)});
        wr(8'h44, 32'hFFFF_0000);
        chk("R11 irq all", {31'h0, irq}, {31'h0, |e_hi});
        wr(8'h40, 32'h0);
        wr(8'h30, 32'h0);
        wr(8'h78, 32'hFFFF_FFFF);
        rd(8'h70, 32'h0, "R10 clear all");
      end
    end

    wr(8'h50, 32'h1);
    wr(8'h60, 32'h1);
    pin_in = 32'h1;
    cyc(3);
    wr(8'h30, 32'h1);
    cyc(1);
    wr(8'h78, 32'h1);
    rd(8'h70, 32'h1, "R10 set wins over clear");
    pin_in = 32'h0;
    cyc(3);
    wr(8'h78, 32'h1);
    rd(8'h70, 32'h0, "R10 clear after level removed");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule